// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a minimal accumulator machine. It steps through each instruction one register transfer per clock, using five internal registers: a program counter, an address latch, a data latch, an instruction holder and an accumulator. It reads instructions and operands through a single synchronous read port. The current accumulator value, the carry from the last addition and the current phase are exposed as outputs so that a test environment can follow progress.

Each instruction word has 16 bits. The high nibble selects the operation and the low 12 bits give a memory address. An instruction first passes through a common fetch sequence that takes five cycles, including the decode step. Load and add then run a four-cycle execute sequence. Every other opcode skips the execute phase, except halt, which stops the core until reset.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, acc_o is 0, carry_o is 0, phase_o is 0 (fetch), mem_rd_o is 0 and mem_addr_o is 0. After release, the first instruction is fetched from address 0.
- R2: mem_rd_o is high for exactly one cycle per memory access, and mem_addr_o does not change in the following cycle. In the fetch phase the strobe appears once per instruction, and the addresses of successive fetches rise by one.
- R3: An instruction word keeps its opcode in bits [15:12] and its operand address in bits [11:0].
- R4: Opcode 0x1 (load) reads the word at the operand address, with a strobe during the execute phase, and writes that word into acc_o.
- R5: Opcode 0x2 (add) reads the word at the operand address and sets acc_o to the previous value plus that word, modulo 2^16. carry_o takes the carry out of bit 15.
- R6: acc_o and carry_o change only at the end of an execute phase. Load and the no-op opcodes leave carry_o unchanged.
- R7: Between fetch strobes, load and add take 9 cycles: 5 cycles in fetch, then 4 cycles in execute.
- R8: Any opcode other than 0x1, 0x2 and 0xF is a no-op. It takes 5 cycles with no execute cycle and no operand read, and it leaves acc_o unchanged.
- R9: Opcode 0xF (halt) moves phase_o to halted. The core then stays halted with mem_rd_o low and acc_o and carry_o frozen until reset.
- R10: phase_o is encoded as 0 = fetch (including decode), 1 = execute, 2 = halted. The value 3 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory read address (address latch) |
| mem_rd_o | output | 1 | Read strobe; data is expected on mem_rdata_i one cycle later |
| mem_rdata_i | input | 16 | Synchronous read data |
| acc_o | output | 16 | Accumulator value |
| carry_o | output | 1 | Carry out of the last add |
| phase_o | output | 2 | Current phase: 0 fetch, 1 execute, 2 halted |

## Verification
The instruction fetch strobe arrives in the second cycle of each instruction. By that point the accumulator and carry show the result of the previous instruction, whose write happened two edges earlier. The operand strobe arrives in the second execute cycle. The scoreboard therefore compares all per-instruction results at fetch strobes, sampling on the falling edge. It also compares the cycle distance between consecutive fetch strobes (9 or 5) and the number of execute-phase cycles in between (4 or 0). The halt result is compared on the first halted cycle, and the core is then observed for 16 more cycles.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  localparam logic [3:0] OPC_LOAD = 4'h1;
  localparam logic [3:0] OPC_ADD  = 4'h2;
  localparam logic [3:0] OPC_HALT = 4'hF;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_RD,
    ST_F_MDR,
    ST_F_IR,
    ST_DECODE,
    ST_X_MAR,
    ST_X_RD,
    ST_X_MDR,
    ST_X_WB,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_HALT  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    OK_NOP,
    OK_LOAD,
    OK_ADD,
    OK_HALT
  } op_kind_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic pc_inc;
    logic mdr_load;
    logic ir_load;
    logic acc_load;
    logic acc_add;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
`timescale 1ns/1ps
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int unsigned OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode_i,
  output op_kind_e         kind_o
);

  always_comb begin
    if (opcode_i == OPC_W'(OPC_LOAD))      kind_o = OK_LOAD;
    else if (opcode_i == OPC_W'(OPC_ADD))  kind_o = OK_ADD;
    else if (opcode_i == OPC_W'(OPC_HALT)) kind_o = OK_HALT;
    else                                   kind_o = OK_NOP;
  end

endmodule

// File: rtl/acc_cpu_adder.sv
`timescale 1ns/1ps
module acc_cpu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);

  logic [W:0] full;

  assign full    = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  op_kind_e kind_i,
  output ctrl_t    ctrl_o,
  output logic     mem_rd_o,
  output phase_e   phase_o
);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_MAR;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    ctrl_o   = '0;
    mem_rd_o = 1'b0;
    unique case (state_q)
      ST_F_MAR: begin
        ctrl_o.mar_from_pc = 1'b1;
        state_d = ST_F_RD;
      end
      ST_F_RD: begin
        ctrl_o.pc_inc = 1'b1;
        mem_rd_o      = 1'b1;
        state_d       = ST_F_MDR;
      end
      ST_F_MDR: begin
        ctrl_o.mdr_load = 1'b1;
        state_d         = ST_F_IR;
      end
      ST_F_IR: begin
        ctrl_o.ir_load = 1'b1;
        state_d        = ST_DECODE;
      end
      ST_DECODE: begin
        unique case (kind_i)
          OK_LOAD, OK_ADD: state_d = ST_X_MAR;
          OK_HALT:         state_d = ST_HALT;
          default:         state_d = ST_F_MAR;
        endcase
      end
      ST_X_MAR: begin
        ctrl_o.mar_from_ir = 1'b1;
        state_d = ST_X_RD;
      end
      ST_X_RD: begin
        mem_rd_o = 1'b1;
        state_d  = ST_X_MDR;
      end
      ST_X_MDR: begin
        ctrl_o.mdr_load = 1'b1;
        state_d         = ST_X_WB;
      end
      ST_X_WB: begin
        // IR is unchanged through execute, so the live decode selects the write
        ctrl_o.acc_load = (kind_i == OK_LOAD);
        ctrl_o.acc_add  = (kind_i == OK_ADD);
        state_d         = ST_F_MAR;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_F_MAR;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_X_MAR, ST_X_RD, ST_X_MDR, ST_X_WB: phase_o = PH_EXEC;
      ST_HALT:                              phase_o = PH_HALT;
      default:                              phase_o = PH_FETCH;
    endcase
  end

endmodule

// File: rtl/acc_cpu_dpath.sv
`timescale 1ns/1ps
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned OPC_W = DATA_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic              carry_q;
  logic [DATA_W-1:0] sum;
  logic              sum_c;

  acc_cpu_adder #(.W(DATA_W)) u_adder (
    .a_i     (acc_q),
    .b_i     (mdr_q),
    .sum_o   (sum),
    .carry_o (sum_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ctrl_i.mar_from_pc)      mar_q <= pc_q;
      else if (ctrl_i.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (ctrl_i.pc_inc)   pc_q  <= pc_q + 1'b1;
      if (ctrl_i.mdr_load) mdr_q <= mem_rdata_i;
      if (ctrl_i.ir_load)  ir_q  <= mdr_q;
      if (ctrl_i.acc_load) begin
        acc_q <= mdr_q;
      end else if (ctrl_i.acc_add) begin
        acc_q   <= sum;
        carry_q <= sum_c;
      end
    end
  end

  assign mem_addr_o = mar_q;
  assign opcode_o   = ir_q[DATA_W-1:ADDR_W];
  assign acc_o      = acc_q;
  assign carry_o    = carry_q;

endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic [1:0]        phase_o
);

  localparam int unsigned OPC_W = DATA_W - ADDR_W;

  ctrl_t            ctrl;
  op_kind_e         kind;
  phase_e           phase;
  logic [OPC_W-1:0] opcode;

  acc_cpu_decode #(.OPC_W(OPC_W)) u_decode (
    .opcode_i (opcode),
    .kind_o   (kind)
  );

  acc_cpu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .ctrl_o   (ctrl),
    .mem_rd_o (mem_rd_o),
    .phase_o  (phase)
  );

  acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .opcode_o    (opcode),
    .acc_o       (acc_o),
    .carry_o     (carry_o)
  );

  assign phase_o = phase;

endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_rd_i,
  input logic [DATA_W-1:0] acc_i,
  input logic              carry_i,
  input logic [1:0]        phase_i
);

  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |=> !mem_rd_i);

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |=> $stable(mem_addr_i));

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd2) |-> !mem_rd_i);

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd2) |=> (phase_i == 2'd2) && $stable(acc_i) && $stable(carry_i));

  // R6
  acc_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_i) |-> ($past(phase_i) == 2'd1));

  // R6
  carry_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carry_i) |-> ($past(phase_i) == 2'd1));

  // R7
  exec_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == 2'd1) && ($past(phase_i) != 2'd1)) |-> ($past(phase_i) == 2'd0));

  // R10
  phase_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != 2'd3);

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_rd_i   (mem_rd_o),
  .acc_i      (acc_o),
  .carry_i    (carry_o),
  .phase_i    (phase_o)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc;
  logic          carry;
  logic [1:0]    phase;

  always #2.5 clk = ~clk;

  acc_cpu uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_rdata_i (mem_rdata),
    .acc_o       (acc),
    .carry_o     (carry),
    .phase_o     (phase)
  );

  logic [DW-1:0] mem [256];

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  // prev: kind of the instruction before this item, 0 none, 1 load, 2 add, 3 no-op
  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] acc;
    logic          c;
    logic [7:0]    gap;
    logic [7:0]    ex;
    logic [1:0]    prev;
  } item_t;

  item_t         exp_q[$];
  item_t         halt_q[$];
  logic [AW-1:0] op_q[$];

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string acc_tag(input logic [1:0] prev);
    case (prev)
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R8";
    endcase
  endfunction

  // monitor
  int   cyc = 0, last = 0, exn = 0;
  bit   halt_seen = 0, rd_in_halt = 0;
  item_t it;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last = 0; exn = 0; halt_seen = 0; rd_in_halt = 0;
    end else begin
      cyc++;
      if (phase == 2'd1) exn++;
      if (mem_rd && phase == 2'd0) begin
        if (exp_q.size() == 0) begin
          check("R2", "unexpected fetch strobe", 32'(mem_addr), 32'hFFFF);
        end else begin
          it = exp_q.pop_front();
          check(it.prev == 2'd0 ? "R1" : "R2", "fetch address", 32'(mem_addr), 32'(it.addr));
          check(acc_tag(it.prev), "acc", 32'(acc), 32'(it.acc));
          check(it.prev == 2'd2 ? "R5" : "R6", "carry", 32'(carry), 32'(it.c));
          if (it.prev != 2'd0) begin
            check(it.prev == 2'd3 ? "R8" : "R7", "cycles per instruction",
                  32'(cyc - last), 32'(it.gap));
            check("R10", "execute-phase cycles", 32'(exn), 32'(it.ex));
          end
        end
        last = cyc;
        exn  = 0;
      end
      if (mem_rd && phase == 2'd1) begin
        if (op_q.size() == 0) check("R8", "unexpected operand read", 32'(mem_addr), 32'hFFFF);
        else check("R3", "operand read address (R4)", 32'(mem_addr), 32'(op_q.pop_front()));
      end
      if (phase == 2'd2) begin
        if (mem_rd) rd_in_halt = 1;
        if (!halt_seen && halt_q.size() != 0) begin
          it = halt_q.pop_front();
          check("R9", "acc at halt", 32'(acc), 32'(it.acc));
          check("R9", "carry at halt", 32'(carry), 32'(it.c));
        end
        halt_seen = 1;
      end
    end
  end

  // driver: model the program from the requirements and queue expected items
  task automatic plan_program(output logic [DW-1:0] final_acc);
    int            pc = 0;
    logic [DW-1:0] a  = '0;
    logic          c  = 1'b0;
    logic [7:0]    gap = 0, ex = 0;
    logic [1:0]    prev = 0;
    for (int n = 0; n < 64; n++) begin
      logic [DW-1:0] ins = mem[pc[7:0]];
      logic [3:0]    opc = ins[15:12];
      logic [AW-1:0] opd = ins[11:0];
      exp_q.push_back('{addr: AW'(pc), acc: a, c: c, gap: gap, ex: ex, prev: prev});
      if (opc == 4'hF) begin
        halt_q.push_back('{addr: AW'(pc), acc: a, c: c, gap: 0, ex: 0, prev: prev});
        break;
      end
      case (opc)
        4'h1: begin
          op_q.push_back(opd); a = mem[opd[7:0]];
          gap = 9; ex = 4; prev = 1;
        end
        4'h2: begin
          logic [DW:0] s = {1'b0, a} + {1'b0, mem[opd[7:0]]};
          op_q.push_back(opd); a = s[DW-1:0]; c = s[DW];
          gap = 9; ex = 4; prev = 2;
        end
        default: begin gap = 5; ex = 0; prev = 3; end
      endcase
      pc++;
    end
    final_acc = a;
  endtask

  task automatic run_program();
    logic [DW-1:0] fa;
    @(negedge clk);
    rst_n = 1'b0;
    plan_program(fa);
    repeat (3) @(negedge clk);
    check("R1", "reset acc", 32'(acc), 0);
    check("R1", "reset carry", 32'(carry), 0);
    check("R1", "reset phase", 32'(phase), 0);
    check("R1", "reset strobe", 32'(mem_rd), 0);
    check("R1", "reset address", 32'(mem_addr), 0);
    rst_n = 1'b1;
    while (!halt_seen) @(negedge clk);
    repeat (16) @(negedge clk);
    check("R9", "phase stays halted (R10)", 32'(phase), 2);
    check("R9", "strobe while halted", 32'(rd_in_halt), 0);
    check("R9", "acc frozen", 32'(acc), 32'(fa));
    check("R2", "fetch items left", 32'(exp_q.size()), 0);
    check("R4", "operand reads left", 32'(op_q.size()), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // load, adds into carry, no-ops, load keeps carry, halt
    mem[0] = 16'h1040; mem[1] = 16'h2041; mem[2] = 16'h2042; mem[3] = 16'h0000;
    mem[4] = 16'h1043; mem[5] = 16'h5123; mem[6] = 16'hF000;
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'h0F00; mem[8'h42] = 16'hF000;
    mem[8'h43] = 16'hABCD;
    run_program();

    for (int i = 0; i < 256; i++) mem[i] = '0;
    // wrap to zero with carry, carry cleared by next add, load keeps carry low
    mem[0] = 16'h2050; mem[1] = 16'h2051; mem[2] = 16'h7051; mem[3] = 16'h2051;
    mem[4] = 16'h1052; mem[5] = 16'hEFFF; mem[6] = 16'hF123;
    mem[8'h50] = 16'hFFFF; mem[8'h51] = 16'h0001; mem[8'h52] = 16'h8000;
    run_program();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual running expected halted");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule